// File: doc/BRIEF.md
# NaN-Propagating Floating-Point Special-Case Front End

This block sits in front of the single-precision arithmetic datapath of each vector lane. Every cycle it takes an operation code and two operands. It settles each case the arithmetic core should never see: any NaN operand, invalid pairings of zero and infinity, exact infinity results, and the complete min/max operations. Each settled case produces a final result word. Any other case raises a `normal` flag and passes the operands and opcode on unchanged, so that the downstream adder, multiplier or divider can compute the result.

The block never raises a trap or a sticky flag. Errors are reported only through quiet NaN values whose payload bits name the class of error. The final result therefore does not depend on how many elements a vector holds. When two NaNs meet, their payloads are merged by bitwise OR, so every opcode gives the same bits with its operands swapped. Min and max return a NaN whenever either operand is a NaN.

The inputs are decoded by combinational logic, and all outputs come from a single register stage.

Top module: `nanprop_fp_front`

## Requirements
- R1: All outputs are registered. `out_valid` equals the `in_valid` of the previous clock, and reset clears `out_valid`, `out_normal` and `out_result`.
- R2: The opcodes are 0 add, 1 sub, 2 mul, 3 div, 4 min and 5 max. Codes 6 and 7 are always reported as normal, even when given infinities.
- R3: When both operands are NaN (exponent all ones, mantissa nonzero), any opcode returns the OR of the two operand words with mantissa bit 22 forced to 1. The sign is the OR of the two signs and the payload (mantissa bits 21..0) is the OR of the two payloads, so swapping the operands changes no bit.
- R4: When exactly one operand is NaN, any opcode returns that operand with mantissa bit 22 set. Its sign and payload are unchanged, and a signalling input is quieted this way.
- R5: Min and max return a NaN whenever at least one operand is NaN, for example min(1.0, NaN) = NaN. Min and max are never reported as normal.
- R6: The invalid cases produce the fresh NaN 0x7FC00001. These cases are ∞+(−∞) on add, ∞−∞ with equal signs on sub, 0×∞ in either order, 0/0 and ∞/∞. In the fresh NaN, payload bit 0 is the infinity/division class. Bit 1 is reserved for log/sqrt/pow domain errors, bit 2 for other math functions and bit 3 for an explicitly assigned NaN.
- R7: Division of a finite nonzero value by ±0 returns an infinity with the XOR of the signs. ∞/finite returns an infinity and finite/∞ returns a zero, both signed the same way.
- R8: Add and sub with one infinity operand, or with two infinities that do not cancel, return that infinity, with b's sign inverted on sub. Mul of an infinity by a nonzero value returns an infinity with the XOR of the signs.
- R9: Min and max of two non-NaN operands follow a total order on sign and magnitude, with −0 below +0. So min(−0,+0) = 0x80000000 and max(−0,+0) = 0x00000000 in either operand order.
- R10: Any other case raises `out_normal` with `out_result` = 0. Finite operands on add, sub, mul and div are such cases, including zero times finite. `out_a`, `out_b` and `out_op` always repeat the inputs of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 3 | Opcode (0 add, 1 sub, 2 mul, 3 div, 4 min, 5 max) |
| in_a | input | 32 | First operand, single precision |
| in_b | input | 32 | Second operand, single precision |
| out_valid | output | 1 | Registered in_valid |
| out_normal | output | 1 | Case left to the arithmetic datapath |
| out_result | output | 32 | Settled result (zero when normal) |
| out_op | output | 3 | Registered opcode for the datapath |
| out_a | output | 32 | Registered first operand |
| out_b | output | 32 | Registered second operand |

## Verification
Every result, flag and forwarded operand is due exactly one rising edge after the inputs that caused it. The bench changes inputs on a falling edge and reads all outputs on the following falling edge, half a period after the register has loaded. Each scenario task therefore compares a whole operation against its own expected word before it applies the next one. For the commutativity checks, each random NaN pair is applied twice, once in each order. Both results are compared with the payload OR computed in the bench and with each other.

// File: rtl/nanprop_pkg.sv
package nanprop_pkg;

   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_MUL  = 3'd2,
      OP_DIV  = 3'd3,
      OP_MIN  = 3'd4,
      OP_MAX  = 3'd5,
      OP_RSV6 = 3'd6,
      OP_RSV7 = 3'd7
   } fp_op_e;

   // Operand classification shared by the decode modules.
   typedef struct packed {
      logic sign;
      logic nan;
      logic inf;
      logic zero;
   } fp_class_t;

   // Payload bit allocation for error classes (low mantissa bits).
   localparam int unsigned PL_INF_DIV  = 0;
   localparam int unsigned PL_LOG_POW  = 1;
   localparam int unsigned PL_OTHER_FN = 2;
   localparam int unsigned PL_ASSIGNED = 3;

endpackage

// File: rtl/nanprop_classify.sv
module nanprop_classify
   import nanprop_pkg::*;
#(
   parameter int unsigned EXP_W = 8,
   parameter int unsigned MAN_W = 23
) (
   input  logic [EXP_W+MAN_W:0] val,
   output fp_class_t            cls
);
   localparam int unsigned W = 1 + EXP_W + MAN_W;

   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] man_f;
   logic             exp_max, exp_min, man_nz;

   assign exp_f   = val[MAN_W +: EXP_W];
   assign man_f   = val[MAN_W-1:0];
   assign exp_max = &exp_f;
   assign exp_min = ~|exp_f;
   assign man_nz  = |man_f;

   assign cls.sign = val[W-1];
   assign cls.nan  = exp_max & man_nz;
   assign cls.inf  = exp_max & ~man_nz;
   assign cls.zero = exp_min & ~man_nz;
endmodule

// File: rtl/nanprop_nan_merge.sv
module nanprop_nan_merge #(
   parameter int unsigned EXP_W    = 8,
   parameter int unsigned MAN_W    = 23,
   parameter bit          MERGE_OR = 1'b1
) (
   input  logic [EXP_W+MAN_W:0] a,
   input  logic [EXP_W+MAN_W:0] b,
   input  logic                 a_nan,
   input  logic                 b_nan,
   output logic                 hit,
   output logic [EXP_W+MAN_W:0] res
);
   localparam int unsigned W = 1 + EXP_W + MAN_W;
   localparam logic [W-1:0] QMASK = W'(1) << (MAN_W - 1);

   logic [W-1:0] both_res;

   generate
      if (MERGE_OR) begin : g_or_merge
         // Exponents are all ones in both words, so a whole-word OR
         // merges sign and payload while keeping the NaN exponent.
         assign both_res = a | b | QMASK;
      end else begin : g_first_wins
         assign both_res = a | QMASK;
      end
   endgenerate

   assign hit = a_nan | b_nan;

   always_comb begin
      if (a_nan && b_nan) res = both_res;
      else if (a_nan)     res = a | QMASK;
      else                res = b | QMASK;
   end
endmodule

// File: rtl/nanprop_inf_zero.sv
module nanprop_inf_zero
   import nanprop_pkg::*;
#(
   parameter int unsigned EXP_W   = 8,
   parameter int unsigned MAN_W   = 23,
   parameter int unsigned INV_BIT = PL_INF_DIV
) (
   input  fp_op_e               op,
   input  fp_class_t            ca,
   input  fp_class_t            cb,
   output logic                 hit,
   output logic [EXP_W+MAN_W:0] res
);
   localparam int unsigned W = 1 + EXP_W + MAN_W;
   localparam logic [EXP_W-1:0] EXP_ONES  = '1;
   localparam logic [MAN_W-1:0] FRESH_MAN =
      (MAN_W'(1) << (MAN_W - 1)) | (MAN_W'(1) << INV_BIT);
   localparam logic [W-1:0] FRESH_NAN = {1'b0, EXP_ONES, FRESH_MAN};

   logic         any_nan;
   logic         sb_eff;
   logic         s_x;
   logic         raw_hit;
   logic [W-1:0] raw_res;

   assign any_nan = ca.nan | cb.nan;
   assign sb_eff  = (op == OP_SUB) ? ~cb.sign : cb.sign;
   assign s_x     = ca.sign ^ cb.sign;

   function automatic logic [W-1:0] inf_of(input logic s);
      return {s, EXP_ONES, {MAN_W{1'b0}}};
   endfunction

   function automatic logic [W-1:0] zero_of(input logic s);
      return {s, {(W-1){1'b0}}};
   endfunction

   always_comb begin
      raw_hit = 1'b0;
      raw_res = '0;
      unique case (op)
         OP_ADD, OP_SUB: begin
            if (ca.inf && cb.inf) begin
               raw_hit = 1'b1;
               raw_res = (ca.sign != sb_eff) ? FRESH_NAN : inf_of(ca.sign);
            end else if (ca.inf) begin
               raw_hit = 1'b1;
               raw_res = inf_of(ca.sign);
            end else if (cb.inf) begin
               raw_hit = 1'b1;
               raw_res = inf_of(sb_eff);
            end
         end
         OP_MUL: begin
            if ((ca.inf && cb.zero) || (ca.zero && cb.inf)) begin
               raw_hit = 1'b1;
               raw_res = FRESH_NAN;
            end else if (ca.inf || cb.inf) begin
               raw_hit = 1'b1;
               raw_res = inf_of(s_x);
            end
         end
         OP_DIV: begin
            if ((ca.zero && cb.zero) || (ca.inf && cb.inf)) begin
               raw_hit = 1'b1;
               raw_res = FRESH_NAN;
            end else if (ca.inf || cb.zero) begin
               raw_hit = 1'b1;
               raw_res = inf_of(s_x);
            end else if (cb.inf) begin
               raw_hit = 1'b1;
               raw_res = zero_of(s_x);
            end
         end
         default: begin
            raw_hit = 1'b0;
            raw_res = '0;
         end
      endcase
   end

   assign hit = raw_hit & ~any_nan;
   assign res = raw_res;
endmodule

// File: rtl/nanprop_minmax.sv
module nanprop_minmax #(
   parameter int unsigned W           = 32,
   parameter bit          ORDER_ZEROS = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         want_max,
   output logic [W-1:0] res
);
   localparam logic [W-1:0] MSB = W'(1) << (W - 1);

   logic [W-1:0] key_a, key_b;
   logic         a_lt_b;

   // Map sign-magnitude onto an unsigned total order.
   function automatic logic [W-1:0] order_key(input logic [W-1:0] x);
      return x[W-1] ? ~x : (x ^ MSB);
   endfunction

   assign key_a = order_key(a);
   assign key_b = order_key(b);

   generate
      if (ORDER_ZEROS) begin : g_total
         assign a_lt_b = key_a < key_b;
      end else begin : g_zero_equal
         logic both_zero;
         assign both_zero = ((a & ~MSB) == '0) && ((b & ~MSB) == '0);
         assign a_lt_b    = !both_zero && (key_a < key_b);
      end
   endgenerate

   always_comb begin
      if (want_max) res = a_lt_b ? b : a;
      else          res = a_lt_b ? a : b;
   end
endmodule

// File: rtl/nanprop_fp_front.sv
module nanprop_fp_front
   import nanprop_pkg::*;
#(
   parameter int unsigned EXP_W       = 8,
   parameter int unsigned MAN_W       = 23,
   parameter int unsigned INV_BIT     = PL_INF_DIV,
   parameter bit          MERGE_OR    = 1'b1,
   parameter bit          ORDER_ZEROS = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [2:0]           in_op,
   input  logic [EXP_W+MAN_W:0] in_a,
   input  logic [EXP_W+MAN_W:0] in_b,
   output logic                 out_valid,
   output logic                 out_normal,
   output logic [EXP_W+MAN_W:0] out_result,
   output logic [2:0]           out_op,
   output logic [EXP_W+MAN_W:0] out_a,
   output logic [EXP_W+MAN_W:0] out_b
);
   localparam int unsigned W      = 1 + EXP_W + MAN_W;
   localparam int unsigned N_OPND = 2;

   // Elaboration-time parameter checks.
   generate
      if (EXP_W < 2) begin : g_bad_exp
         $error("nanprop_fp_front: EXP_W must be at least 2");
      end
      if (MAN_W < PL_ASSIGNED + 3) begin : g_bad_man
         $error("nanprop_fp_front: MAN_W too small for the payload classes");
      end
      if (INV_BIT >= MAN_W - 1) begin : g_bad_inv
         $error("nanprop_fp_front: INV_BIT collides with the quiet bit");
      end
   endgenerate

   fp_op_e       op;
   logic [W-1:0] opnd [N_OPND];
   fp_class_t    cls  [N_OPND];

   assign op      = fp_op_e'(in_op);
   assign opnd[0] = in_a;
   assign opnd[1] = in_b;

   for (genvar gi = 0; gi < N_OPND; gi++) begin : g_cls
      nanprop_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
         .val (opnd[gi]),
         .cls (cls[gi])
      );
   end

   logic         nan_hit;
   logic [W-1:0] nan_res;
   nanprop_nan_merge #(.EXP_W(EXP_W), .MAN_W(MAN_W), .MERGE_OR(MERGE_OR)) u_merge (
      .a     (in_a),
      .b     (in_b),
      .a_nan (cls[0].nan),
      .b_nan (cls[1].nan),
      .hit   (nan_hit),
      .res   (nan_res)
   );

   logic         iz_hit;
   logic [W-1:0] iz_res;
   nanprop_inf_zero #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INV_BIT(INV_BIT)) u_infz (
      .op  (op),
      .ca  (cls[0]),
      .cb  (cls[1]),
      .hit (iz_hit),
      .res (iz_res)
   );

   logic         is_mm;
   logic [W-1:0] mm_res;
   assign is_mm = (op == OP_MIN) || (op == OP_MAX);

   nanprop_minmax #(.W(W), .ORDER_ZEROS(ORDER_ZEROS)) u_mm (
      .a        (in_a),
      .b        (in_b),
      .want_max (op == OP_MAX),
      .res      (mm_res)
   );

   logic         nx_normal;
   logic [W-1:0] nx_result;

   // Priority: NaN operands, then min/max, then zero/infinity cases.
   always_comb begin
      nx_normal = 1'b0;
      nx_result = '0;
      if (nan_hit && op != OP_RSV6 && op != OP_RSV7) begin
         nx_result = nan_res;
      end else if (is_mm) begin
         nx_result = mm_res;
      end else if (iz_hit) begin
         nx_result = iz_res;
      end else begin
         nx_normal = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_normal <= 1'b0;
         out_result <= '0;
         out_op     <= '0;
         out_a      <= '0;
         out_b      <= '0;
      end else begin
         out_valid  <= in_valid;
         out_normal <= nx_normal;
         out_result <= nx_result;
         out_op     <= in_op;
         out_a      <= in_a;
         out_b      <= in_b;
      end
   end
endmodule

// File: rtl/nanprop_fp_front_chk.sv
module nanprop_fp_front_chk #(
   parameter int unsigned EXP_W    = 8,
   parameter int unsigned MAN_W    = 23,
   parameter bit          MERGE_OR = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic [2:0]           in_op,
   input logic [EXP_W+MAN_W:0] in_a,
   input logic [EXP_W+MAN_W:0] in_b,
   input logic                 out_valid,
   input logic                 out_normal,
   input logic [EXP_W+MAN_W:0] out_result,
   input logic [2:0]           out_op,
   input logic [EXP_W+MAN_W:0] out_a,
   input logic [EXP_W+MAN_W:0] out_b
);
   localparam int unsigned W = 1 + EXP_W + MAN_W;
   localparam logic [W-1:0] QMASK = W'(1) << (MAN_W - 1);

   function automatic logic is_nan(input logic [W-1:0] x);
      return (&x[MAN_W +: EXP_W]) && (|x[MAN_W-1:0]);
   endfunction

   logic a_nan, b_nan, known_op, minmax_op;
   assign a_nan     = is_nan(in_a);
   assign b_nan     = is_nan(in_b);
   assign known_op  = in_op <= 3'd5;
   assign minmax_op = (in_op == 3'd4) || (in_op == 3'd5);

   assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> out_valid == $past(in_valid));

   assert_reserved_normal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !known_op |=> out_normal);

   generate
      if (MERGE_OR) begin : g_or_chk
         assert_payload_or_R3: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && known_op && a_nan && b_nan |=>
               out_result == ($past(in_a) | $past(in_b) | QMASK));
      end
   endgenerate

   assert_single_nan_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && known_op && a_nan && !b_nan |=>
         !out_normal && out_result == ($past(in_a) | QMASK));

   assert_minmax_nan_R5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && minmax_op && (a_nan || b_nan) |=> is_nan(out_result));

   assert_minmax_settled_R5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && minmax_op |=> !out_normal);

   assert_minmax_picks_operand_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && minmax_op && !a_nan && !b_nan |=>
         out_result == $past(in_a) || out_result == $past(in_b));

   assert_forward_R10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> out_a == $past(in_a) && out_b == $past(in_b) && out_op == $past(in_op));

   assert_normal_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_normal |-> out_result == '0);
endmodule

bind nanprop_fp_front nanprop_fp_front_chk #(
   .EXP_W(EXP_W), .MAN_W(MAN_W), .MERGE_OR(MERGE_OR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
   .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_normal(out_normal),
   .out_result(out_result), .out_op(out_op), .out_a(out_a), .out_b(out_b)
);

// File: tb/nanprop_fp_front_bench.sv
module nanprop_fp_front_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  in_op = 3'd0;
   logic [31:0] in_a = '0, in_b = '0;
   logic        out_valid, out_normal;
   logic [31:0] out_result, out_a, out_b;
   logic [2:0]  out_op;

   int n_cmp = 0;
   int n_mis = 0;
   bit done  = 1'b0;

   localparam logic [31:0] P_ONE = 32'h3F800000, N_ONE = 32'hBF800000;
   localparam logic [31:0] P_TWO = 32'h40000000, N_TWO = 32'hC0000000;
   localparam logic [31:0] P_INF = 32'h7F800000, N_INF = 32'hFF800000;
   localparam logic [31:0] P_ZERO = 32'h00000000, N_ZERO = 32'h80000000;
   localparam logic [31:0] FRESH = 32'h7FC00001;

   always #5 clk = ~clk;

   nanprop_fp_front u_nanprop_fp_front (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_normal(out_normal),
      .out_result(out_result), .out_op(out_op), .out_a(out_a), .out_b(out_b)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_mis++;
         $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
      end
   endtask

   // Inputs change on a falling edge; results are read one falling edge later.
   task automatic apply(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
      @(negedge clk);
      in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
      @(negedge clk);
   endtask

   task automatic expect_special(input string req, input logic [2:0] op,
                                 input logic [31:0] a, input logic [31:0] b,
                                 input logic [31:0] exp);
      apply(op, a, b);
      chk(req, "valid", {31'd0, out_valid}, 32'd1);
      chk(req, "normal", {31'd0, out_normal}, 32'd0);
      chk(req, "result", out_result, exp);
   endtask

   task automatic expect_normal(input string req, input logic [2:0] op,
                                input logic [31:0] a, input logic [31:0] b);
      apply(op, a, b);
      chk(req, "normal", {31'd0, out_normal}, 32'd1);
      chk(req, "result", out_result, 32'd0);
      chk(req, "fwd a", out_a, a);
      chk(req, "fwd b", out_b, b);
      chk(req, "fwd op", {29'd0, out_op}, {29'd0, op});
   endtask

   function automatic logic [31:0] rand_nan();
      logic        s = 1'($urandom);
      logic        q = 1'($urandom);
      logic [21:0] p = 22'($urandom);
      if (!q && p == '0) p = 22'd1;
      return {s, 8'hFF, q, p};
   endfunction

   task automatic t_reset();
      in_valid = 1'b1; in_a = P_INF; in_b = N_INF;
      repeat (3) @(negedge clk);
      chk("R1", "reset valid", {31'd0, out_valid}, 32'd0);
      chk("R1", "reset normal", {31'd0, out_normal}, 32'd0);
      chk("R1", "reset result", out_result, 32'd0);
      in_valid = 1'b0;
      rst_n = 1'b1;
   endtask

   task automatic t_valid_pipe();
      @(negedge clk);
      in_valid = 1'b0; in_op = 3'd0; in_a = P_ONE; in_b = P_TWO;
      @(negedge clk);
      chk("R1", "idle valid", {31'd0, out_valid}, 32'd0);
      apply(3'd0, P_ONE, P_TWO);
      chk("R1", "one-cycle valid", {31'd0, out_valid}, 32'd1);
   endtask

   task automatic t_nan_pairs();
      for (int op = 0; op < 6; op++) begin
         for (int k = 0; k < 20; k++) begin
            logic [31:0] na = rand_nan();
            logic [31:0] nb = rand_nan();
            logic [31:0] exp = {na[31] | nb[31], 8'hFF, 1'b1, na[21:0] | nb[21:0]};
            logic [31:0] r_ab, r_ba;
            expect_special("R3", 3'(op), na, nb, exp);
            r_ab = out_result;
            expect_special("R3", 3'(op), nb, na, exp);
            r_ba = out_result;
            chk("R3", "swap equal", r_ba, r_ab);
         end
      end
   endtask

   task automatic t_single_nan();
      expect_special("R4", 3'd0, 32'h7F800005, P_ONE, 32'h7FC00005);
      expect_special("R4", 3'd3, P_TWO, 32'hFF812345, 32'hFFC12345);
      expect_special("R4", 3'd2, 32'hFFC00008, P_ZERO, 32'hFFC00008);
      expect_special("R4", 3'd1, P_INF, 32'h7FC00020, 32'h7FC00020);
   endtask

   task automatic t_minmax_nan();
      expect_special("R5", 3'd4, P_ONE, 32'h7FC00008, 32'h7FC00008);
      expect_special("R5", 3'd5, 32'hFF800003, N_INF, 32'hFFC00003);
      expect_special("R5", 3'd4, 32'h7FC00010, N_ONE, 32'h7FC00010);
   endtask

   task automatic t_invalid();
      expect_special("R6", 3'd0, P_INF, N_INF, FRESH);
      expect_special("R6", 3'd0, N_INF, P_INF, FRESH);
      expect_special("R6", 3'd1, P_INF, P_INF, FRESH);
      expect_special("R6", 3'd2, P_ZERO, N_INF, FRESH);
      expect_special("R6", 3'd2, P_INF, N_ZERO, FRESH);
      expect_special("R6", 3'd3, N_ZERO, P_ZERO, FRESH);
      expect_special("R6", 3'd3, P_INF, N_INF, FRESH);
   endtask

   task automatic t_div_special();
      expect_special("R7", 3'd3, P_ONE, P_ZERO, P_INF);
      expect_special("R7", 3'd3, N_ONE, P_ZERO, N_INF);
      expect_special("R7", 3'd3, P_TWO, N_ZERO, N_INF);
      expect_special("R7", 3'd3, N_INF, P_TWO, N_INF);
      expect_special("R7", 3'd3, P_TWO, N_INF, N_ZERO);
   endtask

   task automatic t_inf_arith();
      expect_special("R8", 3'd0, P_INF, P_ONE, P_INF);
      expect_special("R8", 3'd0, P_INF, P_INF, P_INF);
      expect_special("R8", 3'd1, P_ONE, P_INF, N_INF);
      expect_special("R8", 3'd1, N_INF, P_ONE, N_INF);
      expect_special("R8", 3'd1, P_INF, N_INF, P_INF);
      expect_special("R8", 3'd2, N_INF, P_TWO, N_INF);
      expect_special("R8", 3'd2, N_INF, N_INF, P_INF);
   endtask

   task automatic t_minmax_order();
      expect_special("R9", 3'd4, N_ZERO, P_ZERO, N_ZERO);
      expect_special("R9", 3'd4, P_ZERO, N_ZERO, N_ZERO);
      expect_special("R9", 3'd5, N_ZERO, P_ZERO, P_ZERO);
      expect_special("R9", 3'd5, P_ZERO, N_ZERO, P_ZERO);
      expect_special("R9", 3'd4, N_ONE, P_TWO, N_ONE);
      expect_special("R9", 3'd5, N_TWO, N_ONE, N_ONE);
      expect_special("R9", 3'd4, P_TWO, P_ONE, P_ONE);
      expect_special("R9", 3'd4, N_INF, P_ONE, N_INF);
      expect_special("R9", 3'd5, P_INF, P_TWO, P_INF);
   endtask

   task automatic t_normal();
      expect_normal("R10", 3'd0, P_ONE, P_TWO);
      expect_normal("R10", 3'd1, N_TWO, P_ONE);
      expect_normal("R10", 3'd2, P_ZERO, P_TWO);
      expect_normal("R10", 3'd3, P_ZERO, N_ONE);
   endtask

   task automatic t_reserved_ops();
      expect_normal("R2", 3'd6, P_INF, N_INF);
      expect_normal("R2", 3'd7, 32'h7FC00001, P_ONE);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_cmp++;
         n_mis++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_valid_pipe();
      t_reserved_ops();
      t_nan_pairs();
      t_single_nan();
      t_minmax_nan();
      t_invalid();
      t_div_special();
      t_inf_arith();
      t_minmax_order();
      t_normal();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
   end
endmodule